// File: doc/BRIEF.md
# Time-Triggered Compare Match Unit

This block holds three compare channels for a time-triggered CAN controller. It keeps a free-running timer and a cycle-time counter, and each channel compares one of them against its own register. Channel 0 watches the timer and can reset it on a match. Channel 1 watches the cycle-time counter and only raises a flag. Channel 2 also watches the cycle-time counter, and its match asks the mailbox logic to cancel every pending transmission, unless the controller is halted.

Software reaches the compare registers, the flags and both counters through a small register bus with byte addresses. Writes need `bus_sel` and `bus_wr` together. Reads are combinational on `bus_addr`. The timer advances on `tmr_tick`. The cycle counter advances on `cyc_tick` and restarts on `cyc_restart`. The mailbox logic takes the one-cycle cancel pulse together with its mask of pending mailboxes.

Top module: `tt_compare_unit`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the three compare registers read 16'hFFFF. The flags, the timer and the cycle counter read 0, and `txc_valid` is 0.
- R2: The compare registers for channels 0, 1 and 2 are 16-bit read/write registers at byte addresses 0x098, 0x09C and 0x0A0. A write lands at the clock edge and reads back the written value.
- R3: The timer (read-only, address 0x0A8 and port `timer_val`) adds 1 at each edge where `tmr_tick` is high. The cycle counter (read-only, address 0x0AC and port `cycle_val`) adds 1 at each edge where `cyc_tick` is high. `cyc_restart` forces the cycle counter to 0 and takes priority over `cyc_tick`.
- R4: When the timer takes a new value equal to compare 0, flag bit 0 is set one clock later. The flags are at address 0x0A4, bit k for channel k, and also on port `match_flags`.
- R5: When the cycle counter takes a new value equal to compare 1, flag bit 1 is set one clock later. A match against compare 2 sets flag bit 2 in the same way.
- R6: A flag is sticky. A counter that stays at the matching value does not fire again. Writing 1 to a flag bit clears it. A match arriving at the same edge as the clearing write wins, and the flag stays set.
- R7: Writing a compare register with the value its counter already holds produces no match. A new register value is tested only when the counter next changes.
- R8: With `tmr_clr_en` high, a channel 0 match makes the timer read 0 at the same edge that sets the flag, and the timer counts up from 0 after that. This clear wins over `tmr_tick`. Matches on channels 1 and 2 never touch the timer.
- R9: A channel 2 match taken while `ctl_halted` is low drives `txc_valid` high for exactly one cycle, starting at the edge that sets flag 2. During that cycle `txc_mask` carries `tx_pending` as it was in the match cycle. Otherwise `txc_mask` is 0. A match while halted still sets the flag but sends no pulse. Channels 0 and 1 never pulse.
- R10: Writes to an unmapped address, writes to the read-only counter addresses, and bus cycles with `bus_wr` low change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, used together with bus_sel |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on bus_addr |
| tmr_tick | input | 1 | Timer advance strobe |
| tmr_clr_en | input | 1 | Lets a channel 0 match reset the timer |
| cyc_tick | input | 1 | Cycle counter advance strobe |
| cyc_restart | input | 1 | Cycle counter restart to 0 |
| ctl_halted | input | 1 | Controller halted; blocks transmit cancel |
| tx_pending | input | 16 | Mask of mailboxes with a pending transmission |
| match_flags | output | 3 | Sticky match flags, bit k for channel k |
| txc_valid | output | 1 | One-cycle transmit-cancel request |
| txc_mask | output | 16 | Mailboxes to cancel while txc_valid is high |
| timer_val | output | 16 | Current timer value |
| cycle_val | output | 16 | Current cycle counter value |

## Verification
The bench builds the unit with its defaults: 16-bit counters and compare registers, 16 mailboxes, 12-bit byte addresses and the register offsets listed above. With these values the bench steers both counters through small values and hits every match timing. This covers the clear winning over a tick, restarts, cancels while halted and not halted, and a clearing write landing at the same edge as a match. It never drives a counter through its 16-bit wrap.

// File: rtl/tt_compare_unit.sv
module tt_compare_unit #(
  parameter int CNT_W  = 16,
  parameter int MBOX_N = 16,
  parameter int AW     = 12,
  parameter logic [AW-1:0] A_CMP0 = 12'h098,
  parameter logic [AW-1:0] A_CMP1 = 12'h09C,
  parameter logic [AW-1:0] A_CMP2 = 12'h0A0,
  parameter logic [AW-1:0] A_FLAG = 12'h0A4,
  parameter logic [AW-1:0] A_TMR  = 12'h0A8,
  parameter logic [AW-1:0] A_CYC  = 12'h0AC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              tmr_tick,
  input  logic              tmr_clr_en,
  input  logic              cyc_tick,
  input  logic              cyc_restart,
  input  logic              ctl_halted,
  input  logic [MBOX_N-1:0] tx_pending,
  output logic [2:0]        match_flags,
  output logic              txc_valid,
  output logic [MBOX_N-1:0] txc_mask,
  output logic [CNT_W-1:0]  timer_val,
  output logic [CNT_W-1:0]  cycle_val
);
  localparam int NCH = 3;
  localparam logic [AW-1:0] CMP_ADDR [NCH] = '{A_CMP0, A_CMP1, A_CMP2};

  logic [CNT_W-1:0]  cmp_q [NCH];
  logic [CNT_W-1:0]  timer_q, timer_d, cyc_q, cyc_d;
  logic              tmr_new_q, cyc_new_q;
  logic [NCH-1:0]    hit, flag_q, flag_clr;
  logic              wr_en, clr_tmr, fire;
  logic              txc_valid_q;
  logic [MBOX_N-1:0] txc_mask_q;

  assign wr_en    = bus_sel & bus_wr;
  assign flag_clr = (wr_en && bus_addr == A_FLAG) ? bus_wdata[NCH-1:0] : '0;

  assign hit[0]  = tmr_new_q && (timer_q == cmp_q[0]);
  assign hit[1]  = cyc_new_q && (cyc_q == cmp_q[1]);
  assign hit[2]  = cyc_new_q && (cyc_q == cmp_q[2]);
  assign clr_tmr = hit[0] & tmr_clr_en;
  assign fire    = hit[2] & ~ctl_halted;

  assign timer_d = clr_tmr ? '0 : (tmr_tick ? timer_q + 1'b1 : timer_q);
  assign cyc_d   = cyc_restart ? '0 : (cyc_tick ? cyc_q + 1'b1 : cyc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_q     <= '0;
      cyc_q       <= '0;
      tmr_new_q   <= 1'b0;
      cyc_new_q   <= 1'b0;
      flag_q      <= '0;
      txc_valid_q <= 1'b0;
      txc_mask_q  <= '0;
    end else begin
      timer_q     <= timer_d;
      cyc_q       <= cyc_d;
      tmr_new_q   <= timer_d != timer_q;
      cyc_new_q   <= cyc_d != cyc_q;
      flag_q      <= hit | (flag_q & ~flag_clr);
      txc_valid_q <= fire;
      txc_mask_q  <= fire ? tx_pending : '0;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n)                                cmp_q[k] <= '1;
      else if (wr_en && bus_addr == CMP_ADDR[k]) cmp_q[k] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CMP0:  bus_rdata = cmp_q[0];
      A_CMP1:  bus_rdata = cmp_q[1];
      A_CMP2:  bus_rdata = cmp_q[2];
      A_FLAG:  bus_rdata[NCH-1:0] = flag_q;
      A_TMR:   bus_rdata = timer_q;
      A_CYC:   bus_rdata = cyc_q;
      default: bus_rdata = '0;
    endcase
  end

  assign match_flags = flag_q;
  assign txc_valid   = txc_valid_q;
  assign txc_mask    = txc_mask_q;
  assign timer_val   = timer_q;
  assign cycle_val   = cyc_q;
endmodule

// File: rtl/tt_compare_checker.sv
module tt_compare_checker #(
  parameter int CNT_W  = 16,
  parameter int MBOX_N = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tmr_tick,
  input logic              clr_tmr,
  input logic              ctl_halted,
  input logic [CNT_W-1:0]  timer,
  input logic [CNT_W-1:0]  cmp0,
  input logic [CNT_W-1:0]  cmp1,
  input logic [CNT_W-1:0]  cmp2,
  input logic [2:0]        flags,
  input logic              txc_valid,
  input logic [MBOX_N-1:0] txc_mask
);
  p_cmp_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (cmp0 == '1 && cmp1 == '1 && cmp2 == '1 && flags == '0 && !txc_valid));

  p_timer_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_tick && !clr_tmr) |=> timer == CNT_W'($past(timer) + 1'b1));

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_tmr |=> (timer == '0 && flags[0]));

  p_cancel_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    txc_valid |=> !txc_valid);

  p_cancel_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    txc_valid |-> (flags[2] && !$past(ctl_halted)));

  p_mask_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !txc_valid |-> txc_mask == '0);
endmodule

bind tt_compare_unit tt_compare_checker #(.CNT_W(CNT_W), .MBOX_N(MBOX_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .clr_tmr(clr_tmr),
  .ctl_halted(ctl_halted), .timer(timer_q), .cmp0(cmp_q[0]), .cmp1(cmp_q[1]),
  .cmp2(cmp_q[2]), .flags(flag_q), .txc_valid(txc_valid), .txc_mask(txc_mask)
);

// File: tb/tb_tt_compare_unit.sv
module tb_tt_compare_unit;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        tmr_tick = 0, tmr_clr_en = 0, cyc_tick = 0, cyc_restart = 0, ctl_halted = 0;
  logic [15:0] tx_pending = '0, txc_mask, timer_val, cycle_val;
  logic [2:0]  match_flags;
  logic        txc_valid;
  int errors = 0, checks = 0, pulses = 0;
  logic [15:0] rd;

  always #10 clk = ~clk;

  tt_compare_unit dut (.*);

  always @(posedge clk) if (txc_valid) pulses <= pulses + 1;

  typedef struct packed { logic [11:0] waddr; logic [15:0] wdata; logic [11:0] raddr; logic [15:0] exp; } vec_t;
  localparam vec_t VECS [8] = '{
    '{12'h098, 16'h1234, 12'h098, 16'h1234},
    '{12'h09C, 16'hABCD, 12'h09C, 16'hABCD},
    '{12'h0A0, 16'h0F0F, 12'h0A0, 16'h0F0F},
    '{12'h0B0, 16'h5555, 12'h098, 16'h1234},
    '{12'h0A8, 16'h7777, 12'h0A8, 16'h0000},
    '{12'h0AC, 16'h3333, 12'h0AC, 16'h0000},
    '{12'h098, 16'h0100, 12'h098, 16'h0100},
    '{12'h0A4, 16'h0007, 12'h0A4, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rreg(input logic [11:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wreg(input logic [11:0] a, input logic [15:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cycles(3); rst_n = 1;
    rreg(12'h098, rd); chk("R1 cmp0", rd, 16'hFFFF);
    rreg(12'h09C, rd); chk("R1 cmp1", rd, 16'hFFFF);
    rreg(12'h0A0, rd); chk("R1 cmp2", rd, 16'hFFFF);
    rreg(12'h0A4, rd); chk("R1 flags", rd, 0);
    chk("R1 timer/cycle", {timer_val, cycle_val}, 0);
    chk("R1 txc_valid", txc_valid, 0);

    for (int i = 0; i < 8; i++) begin
      wreg(VECS[i].waddr, VECS[i].wdata);
      rreg(VECS[i].raddr, rd);
      chk("R2/R10 vector", rd, VECS[i].exp);
    end

    tmr_tick = 1; cycles(5); tmr_tick = 0;
    rreg(12'h0A8, rd); chk("R3 timer count", rd, 5);
    cyc_tick = 1; cycles(2); cyc_tick = 0;
    rreg(12'h0AC, rd); chk("R3 cycle count", rd, 2);
    cyc_restart = 1; cyc_tick = 1; cycles(1); cyc_restart = 0; cyc_tick = 0;
    chk("R3 restart priority", cycle_val, 0);

    wreg(12'h09C, 16'h0000); cycles(2);
    chk("R7 no match on rewrite", match_flags, 0);

    wreg(12'h098, 16'h0008);
    tmr_tick = 1; cycles(3); tmr_tick = 0;
    chk("R4 timer at 8", timer_val, 8);
    chk("R4 flag not yet", match_flags, 0);
    cycles(1);
    chk("R4 flag0 set", match_flags, 3'b001);
    cycles(3);
    chk("R6 sticky", match_flags, 3'b001);
    wreg(12'h0A4, 16'h0001);
    chk("R6 w1c clear", match_flags, 0);
    cycles(3);
    chk("R6 no refire", match_flags, 0);

    tmr_clr_en = 1;
    wreg(12'h09C, 16'h0003); wreg(12'h0A0, 16'h00FF);
    cyc_tick = 1; cycles(3); cyc_tick = 0;
    chk("R5 cycle at 3", cycle_val, 3);
    chk("R5 flag not yet", match_flags, 0);
    cycles(1);
    chk("R5 flag1 set", match_flags, 3'b010);
    chk("R8 ch1 leaves timer", timer_val, 8);
    chk("R9 ch1 no cancel", {txc_valid, 16'(pulses)}, 0);

    wreg(12'h0A4, 16'h0002);
    tx_pending = 16'hA5C3;
    wreg(12'h0A0, 16'h0005);
    cyc_tick = 1; cycles(2); cyc_tick = 0;
    chk("R9 no pulse in match cycle", txc_valid, 0);
    cycles(1);
    chk("R9 pulse", {txc_valid, txc_mask}, {1'b1, 16'hA5C3});
    chk("R5 flag2 set", match_flags, 3'b100);
    chk("R8 ch2 leaves timer", timer_val, 8);
    cycles(1);
    chk("R9 pulse ends", {txc_valid, txc_mask}, 0);
    chk("R9 one pulse", pulses, 1);

    wreg(12'h0A4, 16'h0004);
    ctl_halted = 1;
    cyc_restart = 1; cycles(1); cyc_restart = 0;
    cyc_tick = 1; cycles(5); cyc_tick = 0;
    cycles(2);
    chk("R9 halted flags", match_flags, 3'b110);
    chk("R9 halted no pulse", {txc_valid, 16'(pulses)}, {1'b0, 16'd1});
    ctl_halted = 0;

    wreg(12'h0A4, 16'h0007);
    wreg(12'h098, 16'h000A);
    tmr_tick = 1; cycles(3); tmr_tick = 0;
    chk("R8 timer cleared", timer_val, 0);
    chk("R8 flag0", match_flags, 3'b001);
    tmr_tick = 1; cycles(4); tmr_tick = 0;
    chk("R8 counts from zero", timer_val, 4);

    wreg(12'h0A4, 16'h0007);
    wreg(12'h098, 16'h0006);
    tmr_tick = 1; cycles(2); tmr_tick = 0;
    wreg(12'h0A4, 16'h0001);
    chk("R6 set wins over clear", match_flags, 3'b001);
    chk("R8 cleared again", timer_val, 0);

    bus_sel = 1; bus_wr = 0; bus_addr = 12'h09C; bus_wdata = 16'hFFFF;
    cycles(1); bus_sel = 0;
    rreg(12'h09C, rd); chk("R10 no write without bus_wr", rd, 16'h0003);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule